// File: doc/BRIEF.md
# Three-Rail Reset Supervisor Sequencer

This block is the clocked decision core of a supervisor that watches three supply rails and a push-button style manual reset. It receives comparator results that are already digital. These are a primary-supply-good flag, a second-rail-good flag, a raw "above threshold" flag for a third rail, and a core-alive flag. The block drives a pair of complementary system reset outputs. A build-time switch selects how the third rail is judged: as an undervoltage monitor, which faults when the rail is below its threshold, or as an overvoltage monitor, which faults when it is above.

Any non-compliant rail, a missing core-alive indication, or a qualified manual request holds the system in reset. Release happens only after every condition has been good for an unbroken, clock-counted timeout. Any disturbance during that window throws the count away. Every asynchronous input passes through a two-flop synchronizer. The timeout and the manual-reset debounce are parameters in clock cycles. A two-bit state output (held, timing, running) makes release timing visible to the exact cycle.

Top module: `rail_reset_supervisor`

## Requirements
- R1: A low primary-good flag, a low second-rail-good flag, or a low core-alive flag is set up before clock edge 1 and held. It puts the block in reset after edge 3 (two synchronizer flops plus the state register). The outputs are unchanged after edge 2.
- R2: With OV_SENSE=0, the third rail faults when rail3_above_i is 0. With OV_SENSE=1, it faults when rail3_above_i is 1. The opposite level is compliant in each variant.
- R3: Suppose all conditions become good before edge 1 and stay good. Then state_o is 1 (timing) and reset is still asserted after edge TIMEOUT_CYC+1. Reset is released after edge TIMEOUT_CYC+2.
- R4: sys_rst_n_o is always the complement of sys_rst_o, and both change on the same clock edge.
- R5: A fault seen while timing returns the state to held and clears the count. A one-cycle low pulse on the primary flag, restored before edge 1, gives held after edge 2. A full TIMEOUT_CYC+2 edges are then needed from that restore.
- R6: A manual-reset low lasting fewer than DEBOUNCE_CYC sampled cycles has no effect on the outputs. A low set before edge 1 and held leaves the outputs running after edge DEBOUNCE_CYC+2 and in reset after edge DEBOUNCE_CYC+3.
- R7: Suppose the manual reset is released before edge 1, with all rails good. Then reset stays asserted through edge TIMEOUT_CYC+2 and is released after edge TIMEOUT_CYC+3.
- R8: While rst is high, the block is held in reset with state_o = 0. Leaving rst starts the same compliance timing as R3.
- R9: state_o encodes held as 0, timing as 1 and running as 2. The value 3 never appears, and state_o is 2 exactly when sys_rst_n_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock; the timeout and debounce count its cycles |
| rst | input | 1 | Synchronous active-high reset |
| core_alive_i | input | 1 | 1 when the core supply is high enough for valid operation (asynchronous) |
| vdd_ok_i | input | 1 | 1 when the primary supply is above its trip point (asynchronous) |
| rail2_ok_i | input | 1 | 1 when the second rail is above its trip point (asynchronous) |
| rail3_above_i | input | 1 | 1 when the third rail is above its trip point (asynchronous) |
| man_rst_n_i | input | 1 | Active-low manual reset request (asynchronous) |
| sys_rst_n_o | output | 1 | Active-low system reset |
| sys_rst_o | output | 1 | Active-high system reset |
| state_o | output | 2 | Sequencer state: 0 held, 1 timing, 2 running |

## Verification
A corrupted sequencer state or timeout count shows up at the ports as a release that comes one or more cycles early or late. The bench pins the release edge exactly after power-up, after each rail fault and after a manual request. A restart that failed to clear the count appears as an early release in the glitch scenario. A debounce counter that is too short lets the sub-threshold manual pulse through within a few cycles. A swapped third-rail sense shows up as an immediate reset in the variant that should stay running.

// File: rtl/rsup_pkg.sv
package rsup_pkg;

    typedef enum logic [1:0] {
        SUP_HOLD   = 2'd0,
        SUP_TIMING = 2'd1,
        SUP_RUN    = 2'd2
    } sup_state_e;

    // Raw monitor inputs as carried through the synchronizer bank.
    typedef struct packed {
        logic core_ok;
        logic rail1_ok;
        logic rail2_ok;
        logic rail3_above;
        logic mr_n;
    } mon_in_s;

    localparam int MON_W = $bits(mon_in_s);

    // Individual fault causes after qualification.
    typedef struct packed {
        logic core;
        logic rail1;
        logic rail2;
        logic rail3;
        logic manual;
    } fault_vec_s;

    function automatic logic any_fault(input fault_vec_s f);
        return |f;
    endfunction

    // Value each synchronized input holds while in reset: the faulting level.
    function automatic logic [MON_W-1:0] sync_reset_value(input logic ov_sense);
        mon_in_s v;
        v.core_ok     = 1'b0;
        v.rail1_ok    = 1'b0;
        v.rail2_ok    = 1'b0;
        v.rail3_above = ov_sense;
        v.mr_n        = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/rsup_sync.sv
module rsup_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) pipe[0] <= RST_VAL;
                    else     pipe[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) pipe[g] <= RST_VAL;
                    else     pipe[g] <= pipe[g-1];
                end
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/rsup_mr_qual.sv
module rsup_mr_qual #(
    parameter int DEB_CYC = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic mr_n_s,
    output logic req
);
    localparam int DW = (DEB_CYC < 2) ? 1 : $clog2(DEB_CYC + 1);
    localparam logic [DW-1:0] LAST = DW'(DEB_CYC - 1);

    logic [DW-1:0] low_cnt;
    logic          req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
            req_q   <= 1'b0;
        end else if (mr_n_s) begin
            low_cnt <= '0;
            req_q   <= 1'b0;
        end else if (!req_q) begin
            if (low_cnt == LAST) req_q <= 1'b1;
            else                 low_cnt <= low_cnt + 1'b1;
        end
    end

    assign req = req_q;
endmodule

// File: rtl/rsup_seq.sv
module rsup_seq
    import rsup_pkg::*;
#(
    parameter int TIMEOUT_CYC = 40_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fault,
    output sup_state_e state,
    output logic       rst_hi,
    output logic       rst_lo_n
);
    localparam int CW = (TIMEOUT_CYC < 2) ? 1 : $clog2(TIMEOUT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

    sup_state_e st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic hi_q, lo_n_q;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (fault) begin
            st_d  = SUP_HOLD;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                SUP_HOLD: begin
                    if (TIMEOUT_CYC <= 1) begin
                        st_d = SUP_RUN;
                    end else begin
                        st_d  = SUP_TIMING;
                        cnt_d = CW'(1);
                    end
                end
                SUP_TIMING: begin
                    if (cnt_q == LAST) begin
                        st_d  = SUP_RUN;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                SUP_RUN: st_d = SUP_RUN;
                default: begin
                    st_d  = SUP_HOLD;
                    cnt_d = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= SUP_HOLD;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // The two output registers are loaded from the same next state.
    always_ff @(posedge clk) begin
        if (rst) hi_q <= 1'b1;
        else     hi_q <= (st_d != SUP_RUN);
    end

    always_ff @(posedge clk) begin
        if (rst) lo_n_q <= 1'b0;
        else     lo_n_q <= (st_d == SUP_RUN);
    end

    assign state    = st_q;
    assign rst_hi   = hi_q;
    assign rst_lo_n = lo_n_q;
endmodule

// File: rtl/rail_reset_supervisor.sv
module rail_reset_supervisor
    import rsup_pkg::*;
#(
    parameter int TIMEOUT_CYC  = 40_000_000,
    parameter int DEBOUNCE_CYC = 200,
    parameter bit OV_SENSE     = 1'b0,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       core_alive_i,
    input  logic       vdd_ok_i,
    input  logic       rail2_ok_i,
    input  logic       rail3_above_i,
    input  logic       man_rst_n_i,
    output logic       sys_rst_n_o,
    output logic       sys_rst_o,
    output logic [1:0] state_o
);
    localparam logic [MON_W-1:0] SYNC_RST = sync_reset_value(OV_SENSE);

    mon_in_s    raw, syn;
    fault_vec_s fv;
    logic       mr_req;
    logic       rail3_bad;
    sup_state_e st;

    assign raw.core_ok     = core_alive_i;
    assign raw.rail1_ok    = vdd_ok_i;
    assign raw.rail2_ok    = rail2_ok_i;
    assign raw.rail3_above = rail3_above_i;
    assign raw.mr_n        = man_rst_n_i;

    rsup_sync #(
        .W      (MON_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(SYNC_RST)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (raw),
        .q  (syn)
    );

    rsup_mr_qual #(
        .DEB_CYC(DEBOUNCE_CYC)
    ) u_mr (
        .clk   (clk),
        .rst   (rst),
        .mr_n_s(syn.mr_n),
        .req   (mr_req)
    );

    generate
        if (OV_SENSE) begin : g_over
            assign rail3_bad = syn.rail3_above;
        end else begin : g_under
            assign rail3_bad = ~syn.rail3_above;
        end
    endgenerate

    assign fv.core   = ~syn.core_ok;
    assign fv.rail1  = ~syn.rail1_ok;
    assign fv.rail2  = ~syn.rail2_ok;
    assign fv.rail3  = rail3_bad;
    assign fv.manual = mr_req;

    rsup_seq #(
        .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .fault   (any_fault(fv)),
        .state   (st),
        .rst_hi  (sys_rst_o),
        .rst_lo_n(sys_rst_n_o)
    );

    assign state_o = st;
endmodule

// File: rtl/rsup_checker.sv
module rsup_checker #(
    parameter int TIMEOUT_CYC = 40_000_000
) (
    input logic       clk,
    input logic       rst,
    input logic       core_alive_i,
    input logic       vdd_ok_i,
    input logic       rail2_ok_i,
    input logic       sys_rst_n_o,
    input logic       sys_rst_o,
    input logic [1:0] state_o
);
    int unsigned timing_run;

    always_ff @(posedge clk) begin
        if (rst)                timing_run <= 0;
        else if (state_o == 2'd1) timing_run <= timing_run + 1;
        else                    timing_run <= 0;
    end

    // R4: complementary outputs
    a_r4_complement: assert property (@(posedge clk) disable iff (rst)
        sys_rst_n_o != sys_rst_o);

    // R1: primary low three edges ago forces reset
    a_r1_primary_low: assert property (@(posedge clk) disable iff (rst)
        !$past(vdd_ok_i, 3) |-> sys_rst_o);

    // R1: second rail low three edges ago forces reset
    a_r1_second_low: assert property (@(posedge clk) disable iff (rst)
        !$past(rail2_ok_i, 3) |-> sys_rst_o);

    // R1: core not alive three edges ago forces reset
    a_r1_core_low: assert property (@(posedge clk) disable iff (rst)
        !$past(core_alive_i, 3) |-> sys_rst_o);

    // R3: release only follows a compliant sample
    a_r3_release_after_good: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_rst_n_o) |-> ($past(vdd_ok_i, 3) && $past(rail2_ok_i, 3)
                                && $past(core_alive_i, 3)));

    // R3: timing window never outlasts the timeout
    a_r3_timing_bounded: assert property (@(posedge clk) disable iff (rst)
        timing_run <= TIMEOUT_CYC);

    // R9: legal encoding, running matches released output
    a_r9_encoding: assert property (@(posedge clk) disable iff (rst)
        state_o != 2'd3);

    a_r9_run_released: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd2) == sys_rst_n_o);
endmodule

bind rail_reset_supervisor rsup_checker #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .core_alive_i(core_alive_i),
    .vdd_ok_i    (vdd_ok_i),
    .rail2_ok_i  (rail2_ok_i),
    .sys_rst_n_o (sys_rst_n_o),
    .sys_rst_o   (sys_rst_o),
    .state_o     (state_o)
);

// File: tb/sim_rail_reset_supervisor.sv
`timescale 1ns/1ps
module sim_rail_reset_supervisor;
    localparam int T = 20;
    localparam int D = 4;
    localparam int HOLD = 0, TIMING = 1, RUN = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic core_ok = 1'b1, vdd_ok = 1'b1, r2_ok = 1'b1, mr_n = 1'b1;
    logic r3a = 1'b1;   // UV instance: compliant when above
    logic r3b = 1'b0;   // OV instance: compliant when below
    logic a_rst_n, a_rst, b_rst_n, b_rst;
    logic [1:0] a_st, b_st;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    rail_reset_supervisor #(.TIMEOUT_CYC(T), .DEBOUNCE_CYC(D), .OV_SENSE(1'b0)) u0 (
        .clk(clk), .rst(rst), .core_alive_i(core_ok), .vdd_ok_i(vdd_ok),
        .rail2_ok_i(r2_ok), .rail3_above_i(r3a), .man_rst_n_i(mr_n),
        .sys_rst_n_o(a_rst_n), .sys_rst_o(a_rst), .state_o(a_st));

    rail_reset_supervisor #(.TIMEOUT_CYC(T), .DEBOUNCE_CYC(D), .OV_SENSE(1'b1)) u1 (
        .clk(clk), .rst(rst), .core_alive_i(core_ok), .vdd_ok_i(vdd_ok),
        .rail2_ok_i(r2_ok), .rail3_above_i(r3b), .man_rst_n_i(mr_n),
        .sys_rst_n_o(b_rst_n), .sys_rst_o(b_rst), .state_o(b_st));

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // R4 and R9 are checked on every state check
    task automatic chk_a(input string tag, input int exp);
        chk({tag, " u0 state (R9)"}, int'(a_st), exp);
        chk({tag, " u0 sys_rst (R4)"}, int'(a_rst), int'(exp != RUN));
        chk({tag, " u0 sys_rst_n (R4)"}, int'(a_rst_n), int'(exp == RUN));
    endtask

    task automatic chk_b(input string tag, input int exp);
        chk({tag, " u1 state (R9)"}, int'(b_st), exp);
        chk({tag, " u1 sys_rst (R4)"}, int'(b_rst), int'(exp != RUN));
        chk({tag, " u1 sys_rst_n (R4)"}, int'(b_rst_n), int'(exp == RUN));
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic t_power_up();
        edges(3);
        chk_a("R8 in reset", HOLD);
        chk_b("R8 in reset", HOLD);
        @(negedge clk) rst = 1'b0;
        edges(T + 1);
        chk_a("R3 R8 still timing", TIMING);
        edges(1);
        chk_a("R3 R8 released", RUN);
        chk_b("R3 R8 released", RUN);
    endtask

    task automatic set_line(input int which, input logic v);
        case (which)
            0: vdd_ok  = v;
            1: r2_ok   = v;
            default: core_ok = v;
        endcase
    endtask

    task automatic t_rail_fault(input int which, input string tag);
        @(negedge clk) set_line(which, 1'b0);
        edges(2);
        chk_a({tag, " R1 not yet"}, RUN);
        edges(1);
        chk_a({tag, " R1 asserted"}, HOLD);
        edges(4);
        chk_a({tag, " R1 held"}, HOLD);
        @(negedge clk) set_line(which, 1'b1);
        edges(T + 1);
        chk_a({tag, " R3 still timing"}, TIMING);
        edges(1);
        chk_a({tag, " R3 released"}, RUN);
    endtask

    task automatic t_polarity();
        @(negedge clk) r3a = 1'b0;
        edges(3);
        chk_a("R2 UV below faults", HOLD);
        chk_b("R2 OV ignores below", RUN);
        @(negedge clk) r3a = 1'b1;
        edges(T + 2);
        chk_a("R2 UV recovered", RUN);
        @(negedge clk) r3b = 1'b1;
        edges(3);
        chk_b("R2 OV above faults", HOLD);
        chk_a("R2 UV ignores above", RUN);
        @(negedge clk) r3b = 1'b0;
        edges(T + 1);
        chk_b("R2 OV still timing", TIMING);
        edges(1);
        chk_b("R2 OV recovered", RUN);
    endtask

    task automatic t_restart();
        @(negedge clk) vdd_ok = 1'b0;
        edges(3);
        chk_a("R5 entry", HOLD);
        @(negedge clk) vdd_ok = 1'b1;
        edges(T / 2);
        chk_a("R5 mid timing", TIMING);
        @(negedge clk) vdd_ok = 1'b0;
        @(negedge clk) vdd_ok = 1'b1;
        edges(2);
        chk_a("R5 glitch restarts", HOLD);
        edges(T - 1);
        chk_a("R5 full window again", TIMING);
        edges(1);
        chk_a("R5 released", RUN);
    endtask

    task automatic t_mr_short();
        @(negedge clk) mr_n = 1'b0;
        repeat (D - 1) @(negedge clk);
        mr_n = 1'b1;
        for (int i = 0; i < D + 6; i++) begin
            edges(1);
            chk("R6 short pulse ignored sys_rst_n", int'(a_rst_n), 1);
        end
    endtask

    task automatic t_mr_long();
        @(negedge clk) mr_n = 1'b0;
        edges(D + 2);
        chk_a("R6 before qualify", RUN);
        edges(1);
        chk_a("R6 qualified", HOLD);
        edges(5);
        chk_a("R6 held", HOLD);
        @(negedge clk) mr_n = 1'b1;
        edges(T + 2);
        chk_a("R7 still timing", TIMING);
        edges(1);
        chk_a("R7 released", RUN);
    endtask

    initial begin
        #(5.0 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        t_power_up();
        t_rail_fault(0, "primary");
        t_rail_fault(1, "second");
        t_rail_fault(2, "core R8");
        t_polarity();
        t_restart();
        t_mr_short();
        t_mr_long();
        edges(2);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule